// File: doc/BRIEF.md
# Reconstruction-Error Outlier Detector

This block scores how well an autoencoder reproduced its input and turns that score into a normal or anomalous verdict. Each cycle in which `pair_valid` is high, it accepts one original feature value and the matching reconstructed value. It squares their difference and adds the result to a running sum. After `NUM_FEAT` accepted pairs the vector is closed and the sum is handed to a serial divider. The divider produces the mean squared error in the same unsigned fixed-point format as the threshold. The mean is compared with a threshold supplied on a port, and a one-cycle `verdict_valid` strobe presents the verdict together with the score.

The accumulator restarts as soon as a vector closes, so the pairs of the next vector may stream in while the previous division is still running. The accumulator width is a parameter. When it is too narrow for the worst case, the sum saturates instead of wrapping, and a saturated vector is always reported as anomalous. With the default 16 fractional bits, a threshold of 0.001 corresponds to 66 LSB.

Top module: `mse_outlier_scorer`

## Requirements
- R1: `feat_x` and `feat_z` are unsigned with `DATA_W` bits, of which `FRAC_W` are fractional. Each accepted pair adds (x−z)² to the vector sum, so swapping x and z gives the same result.
- R2: A cycle with `pair_valid` low adds nothing to the sum and does not advance the pair count, so idle cycles inside a vector leave the score unchanged.
- R3: After exactly `NUM_FEAT` accepted pairs the vector closes and the sum and count restart from zero. The next vector's pairs may be accepted while the previous vector is still being divided.
- R4: `score` = floor(S / (`NUM_FEAT`·2^`FRAC_W`)), where S is the vector sum in units of 2^−2·`FRAC_W`. That is, `score` is the mean squared error truncated to units of 2^−`FRAC_W`. It is `SCORE_W` = `ACC_W`−`FRAC_W` bits wide.
- R5: `anomalous` is 1 when `score` > `threshold` and 0 otherwise. A score equal to the threshold is normal. `threshold` uses the same format as `score` and must be stable from the last pair of a vector until its strobe.
- R6: If the sum would exceed 2^`ACC_W`−1, it is held at 2^`ACC_W`−1 and `score` is computed from that value. Such a vector is reported anomalous for every threshold value.
- R7: `verdict_valid` is high for exactly one cycle. It rises on rising edge number `SCORE_W`+2, where the edge that accepts the vector's last pair counts as edge 1.
- R8: After reset `verdict_valid`, `anomalous` and `score` are 0. `score` and `anomalous` change only on a strobe and hold their values between strobes.
- R9: A vector's last pair must not be accepted before the edge that raises the previous vector's strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pair_valid | input | 1 | A feature pair is present this cycle |
| feat_x | input | DATA_W | Original feature value |
| feat_z | input | DATA_W | Reconstructed feature value |
| threshold | input | SCORE_W | Anomaly threshold, same format as score |
| verdict_valid | output | 1 | One-cycle strobe marking a new verdict |
| anomalous | output | 1 | 1 = anomalous, 0 = normal |
| score | output | SCORE_W | Mean squared error of the last vector |

## Verification
Two situations are hard to reach from the ports.

The first is the saturating sum. With the default width it cannot overflow, so the bench uses a narrow accumulator with four features. One vector of full-scale differences and many pseudo-random vectors then drive the sum past its ceiling, and the bench sets the threshold above the saturated score to show that the verdict is still anomalous.

The second is the overlap of one vector's accumulation with the previous vector's division. The bench streams three pairs of the next vector right behind a vector's last pair and then checks both results. The equal-to-threshold boundary is reached by computing the score in the bench first and then setting the threshold to that score, one below it and one above it.

// File: rtl/mse_pkg.sv
package mse_pkg;
   // Number of bits needed to count 0..n inclusive.
   function automatic int count_bits(input int n);
      return (n < 1) ? 1 : $clog2(n + 1);
   endfunction
endpackage

// File: rtl/mse_sqdiff.sv
module mse_sqdiff #(
   parameter int DATA_W = 18
) (
   input  logic [DATA_W-1:0]   x_i,
   input  logic [DATA_W-1:0]   z_i,
   output logic [2*DATA_W-1:0] sq_o
);
   localparam int SQ_W = 2 * DATA_W;

   logic [DATA_W-1:0] mag;

   // Absolute difference first, so the multiplier is unsigned.
   always_comb begin
      mag  = (x_i >= z_i) ? (x_i - z_i) : (z_i - x_i);
      sq_o = SQ_W'(mag) * SQ_W'(mag);
   end
endmodule

// File: rtl/mse_accum.sv
module mse_accum
   import mse_pkg::*;
#(
   parameter int DATA_W   = 18,
   parameter int NUM_FEAT = 122,
   parameter int ACC_W    = 43
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  pair_v,
   input  logic [2*DATA_W-1:0]   sq,
   output logic                  vec_done,
   output logic [ACC_W-1:0]      vec_total,
   output logic                  vec_sat
);
   localparam int SQ_W   = 2 * DATA_W;
   localparam int CNT_W  = count_bits(NUM_FEAT);
   localparam int FULL_W = SQ_W + CNT_W;

   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] sum;
   logic [CNT_W-1:0] cnt_q;
   logic             ovf;
   logic             sat_q;
   logic             last;

   generate
      if (ACC_W >= FULL_W) begin : g_wide
         // The sum can never exceed the register: no saturation logic.
         assign sum = acc_q + ACC_W'(sq);
         assign ovf = 1'b0;
      end else begin : g_sat
         logic [ACC_W:0] wide;
         assign wide = {1'b0, acc_q} + (ACC_W + 1)'(sq);
         assign ovf  = wide[ACC_W];
         assign sum  = ovf ? {ACC_W{1'b1}} : wide[ACC_W-1:0];
      end
   endgenerate

   assign last = pair_v && (cnt_q == CNT_W'(NUM_FEAT - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q     <= '0;
         cnt_q     <= '0;
         sat_q     <= 1'b0;
         vec_done  <= 1'b0;
         vec_total <= '0;
         vec_sat   <= 1'b0;
      end else begin
         vec_done <= last;
         if (last) begin
            vec_total <= sum;
            vec_sat   <= sat_q | ovf;
            acc_q     <= '0;
            cnt_q     <= '0;
            sat_q     <= 1'b0;
         end else if (pair_v) begin
            acc_q <= sum;
            cnt_q <= cnt_q + CNT_W'(1);
            sat_q <= sat_q | ovf;
         end
      end
   end

   // R3
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < CNT_W'(NUM_FEAT));
   // R3
   acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vec_done |-> (acc_q == '0 || pair_v) && (cnt_q <= CNT_W'(1)));
   // R6
   no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pair_v && !last) |=> acc_q >= $past(acc_q));
   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pair_v |=> $stable(acc_q) && $stable(cnt_q));
endmodule

// File: rtl/mse_divider.sv
module mse_divider
   import mse_pkg::*;
#(
   parameter int ACC_W    = 43,
   parameter int FRAC_W   = 16,
   parameter int NUM_FEAT = 122
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start,
   input  logic [ACC_W-1:0]          dividend,
   input  logic                      sat_in,
   output logic                      fin,
   output logic [ACC_W-FRAC_W-1:0]   quot,
   output logic                      sat_out
);
   localparam int SCORE_W = ACC_W - FRAC_W;
   localparam int CNT_W   = count_bits(NUM_FEAT);
   localparam int DIVW    = FRAC_W + CNT_W;
   localparam int DW      = DIVW + 1;
   localparam int IT_W    = count_bits(SCORE_W);
   localparam logic [DW-1:0] DIVISOR = DW'(NUM_FEAT) << FRAC_W;

   logic               busy_q;
   logic [IT_W-1:0]    it_q;
   logic [DIVW-1:0]    rem_q;
   logic [DIVW-1:0]    rem_n;
   logic [SCORE_W-1:0] dvd_q;
   logic [SCORE_W-1:0] q_q;
   logic [SCORE_W-1:0] q_n;
   logic [DW-1:0]      trial;
   logic               ge;

   // One restoring step per cycle. The top FRAC_W dividend bits are below
   // the divisor, so they seed the remainder and only SCORE_W steps remain.
   always_comb begin
      trial = {rem_q, dvd_q[SCORE_W-1]};
      ge    = (trial >= DIVISOR);
      rem_n = ge ? DIVW'(trial - DIVISOR) : trial[DIVW-1:0];
      q_n   = {q_q[SCORE_W-2:0], ge};
   end

   assign fin  = busy_q && (it_q == IT_W'(1));
   assign quot = q_n;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         it_q    <= '0;
         rem_q   <= '0;
         dvd_q   <= '0;
         q_q     <= '0;
         sat_out <= 1'b0;
      end else if (start) begin
         busy_q  <= 1'b1;
         it_q    <= IT_W'(SCORE_W);
         rem_q   <= DIVW'(dividend[ACC_W-1 -: FRAC_W]);
         dvd_q   <= dividend[SCORE_W-1:0];
         q_q     <= '0;
         sat_out <= sat_in;
      end else if (busy_q) begin
         rem_q <= rem_n;
         dvd_q <= dvd_q << 1;
         q_q   <= q_n;
         it_q  <= it_q - IT_W'(1);
         if (fin) busy_q <= 1'b0;
      end
   end

   // R9
   start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy_q);
   // R4
   rem_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> DW'(rem_q) < DIVISOR);
   // R7
   fin_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fin |=> !busy_q);
endmodule

// File: rtl/mse_outlier_scorer.sv
module mse_outlier_scorer
   import mse_pkg::*;
#(
   parameter int DATA_W   = 18,
   parameter int FRAC_W   = 16,
   parameter int NUM_FEAT = 122,
   parameter int ACC_W    = 2 * DATA_W + count_bits(NUM_FEAT),
   localparam int SCORE_W = ACC_W - FRAC_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pair_valid,
   input  logic [DATA_W-1:0]  feat_x,
   input  logic [DATA_W-1:0]  feat_z,
   input  logic [SCORE_W-1:0] threshold,
   output logic               verdict_valid,
   output logic               anomalous,
   output logic [SCORE_W-1:0] score
);
   generate
      if (FRAC_W < 16)        begin : g_bad_frac $error("FRAC_W must be at least 16"); end
      if (DATA_W <= FRAC_W)   begin : g_bad_data $error("DATA_W must exceed FRAC_W"); end
      if (ACC_W < 2 * DATA_W) begin : g_bad_acc  $error("ACC_W must hold one square"); end
      if (NUM_FEAT < 1)       begin : g_bad_num  $error("NUM_FEAT must be positive"); end
   endgenerate

   logic [2*DATA_W-1:0] sq;
   logic                vec_done;
   logic [ACC_W-1:0]    vec_total;
   logic                vec_sat;
   logic                fin;
   logic [SCORE_W-1:0]  quot;
   logic                sat_d;

   mse_sqdiff #(.DATA_W(DATA_W)) u_sq (
      .x_i (feat_x),
      .z_i (feat_z),
      .sq_o(sq)
   );

   mse_accum #(.DATA_W(DATA_W), .NUM_FEAT(NUM_FEAT), .ACC_W(ACC_W)) u_acc (
      .clk      (clk),
      .rst_n    (rst_n),
      .pair_v   (pair_valid),
      .sq       (sq),
      .vec_done (vec_done),
      .vec_total(vec_total),
      .vec_sat  (vec_sat)
   );

   mse_divider #(.ACC_W(ACC_W), .FRAC_W(FRAC_W), .NUM_FEAT(NUM_FEAT)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (vec_done),
      .dividend(vec_total),
      .sat_in  (vec_sat),
      .fin     (fin),
      .quot    (quot),
      .sat_out (sat_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         verdict_valid <= 1'b0;
         anomalous     <= 1'b0;
         score         <= '0;
      end else begin
         verdict_valid <= fin;
         if (fin) begin
            score     <= quot;
            anomalous <= sat_d | (quot > threshold);
         end
      end
   end

   // R7
   strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      verdict_valid |=> !verdict_valid);
   // R8
   hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !verdict_valid |-> $stable(score) && $stable(anomalous));
   // R6
   sat_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fin && sat_d) |=> anomalous);
endmodule

// File: tb/sim_mse_outlier_scorer.sv
`timescale 1ns/1ps
module sim_mse_outlier_scorer;
   localparam int DW  = 18;
   localparam int FW  = 16;
   localparam int NF  = 4;
   localparam int AW  = 36;
   localparam int SW  = AW - FW;
   localparam longint MAXACC = (64'sd1 <<< AW) - 1;
   localparam longint DEN    = longint'(NF) <<< FW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          pv = 1'b0;
   logic [DW-1:0] fx = '0;
   logic [DW-1:0] fz = '0;
   logic [SW-1:0] thr = '0;
   logic          vv;
   logic          anom;
   logic [SW-1:0] score;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int unsigned lcg = 32'h1234_5678;

   logic [DW-1:0] vx[NF];
   logic [DW-1:0] vz[NF];

   mse_outlier_scorer #(.DATA_W(DW), .FRAC_W(FW), .NUM_FEAT(NF), .ACC_W(AW)) u0 (
      .clk(clk), .rst_n(rst_n), .pair_valid(pv), .feat_x(fx), .feat_z(fz),
      .threshold(thr), .verdict_valid(vv), .anomalous(anom), .score(score)
   );

   always #10 clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         checks = checks + 1;
         errors = errors + 1;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks = checks + 1;
      if (!ok) begin
         errors = errors + 1;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int unsigned next_rand();
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      return lcg;
   endfunction

   // Expected score and saturation from the requirements (R1, R4, R6).
   task automatic model(output longint es, output bit sat);
      longint tot = 0;
      for (int i = 0; i < NF; i++) begin
         longint d = (vx[i] >= vz[i]) ? longint'(vx[i]) - longint'(vz[i])
                                      : longint'(vz[i]) - longint'(vx[i]);
         tot += d * d;
      end
      sat = (tot > MAXACC);
      es  = (sat ? MAXACC : tot) / DEN;
   endtask

   task automatic push(input logic [DW-1:0] x, input logic [DW-1:0] z);
      pv = 1'b1; fx = x; fz = z;
      @(negedge clk);
      pv = 1'b0;
   endtask

   task automatic wait_strobe(output int lat);
      lat = 0;
      do begin
         @(negedge clk);
         lat++;
      end while (!vv && lat < 200);
   endtask

   task automatic check_result(input longint es, input bit sat, input string req);
      bit ea = sat || (es > longint'(thr));
      chk(vv == 1'b1, {req, " strobe"}, vv, 1);
      chk(longint'(score) == es, {req, " score"}, score, es);
      chk(anom == ea, {req, " verdict"}, anom, ea);
   endtask

   task automatic run_vec(input longint t, input string req, input bit gaps);
      longint es; bit sat; int lat;
      logic [SW-1:0] held;
      logic hanom;
      thr = SW'(t);
      model(es, sat);
      for (int i = 0; i < NF; i++) begin
         push(vx[i], vz[i]);
         if (gaps && i < NF - 1) repeat (3) @(negedge clk);
      end
      wait_strobe(lat);
      check_result(es, sat, req);
      // R7: counting from the negedge after the last pair's edge, the strobe
      // shows SW+1 negedges later (edge SW+2 counting the accepting edge).
      chk(lat == SW + 1, "R7 latency", lat, SW + 1);
      held = score; hanom = anom;
      @(negedge clk);
      chk(vv == 1'b0, "R7 single-cycle strobe", vv, 0);
      repeat (4) @(negedge clk);
      chk(score == held && anom == hanom, "R8 hold between strobes", score, held);
   endtask

   initial begin
      longint es, es2; bit sat, sat2; int lat;
      repeat (3) @(negedge clk);
      chk(vv == 1'b0 && anom == 1'b0 && score == '0, "R8 reset state", score, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(vv == 1'b0 && score == '0, "R8 after reset release", vv, 0);

      // R1/R5: perfect reconstruction, score 0, threshold 0 -> normal
      for (int i = 0; i < NF; i++) begin vx[i] = DW'(1000 * i + 7); vz[i] = vx[i]; end
      run_vec(0, "R1 zero error", 1'b0);

      // R1: swapping x and z gives the same score
      for (int i = 0; i < NF; i++) begin vx[i] = DW'(50000 + i * 3000); vz[i] = DW'(20000 + i * 100); end
      model(es, sat);
      run_vec(es, "R1 x above z", 1'b0);
      for (int i = 0; i < NF; i++) begin logic [DW-1:0] t = vx[i]; vx[i] = vz[i]; vz[i] = t; end
      run_vec(es, "R1 x below z", 1'b0);

      // R5: threshold equality boundary
      model(es, sat);
      run_vec(es, "R5 score equals threshold", 1'b0);
      run_vec(es - 1, "R5 score above threshold", 1'b0);
      run_vec(es + 1, "R5 score below threshold", 1'b0);

      // R4/R5: default threshold 0.001 -> 66 LSB
      for (int i = 0; i < NF; i++) begin vx[i] = DW'(9000); vz[i] = DW'(9000); end
      vx[2] = DW'(9000 + 4160);
      run_vec(66, "R4 score 66 at threshold 66", 1'b0);
      vx[2] = DW'(9000 + 4200);
      run_vec(66, "R4 score 67 at threshold 66", 1'b0);

      // R2: idle cycles between pairs do not change the score
      for (int i = 0; i < NF; i++) begin vx[i] = DW'(70000 - i * 9000); vz[i] = DW'(1000 + i * 4000); end
      model(es, sat);
      run_vec(es - 2, "R2 idle gaps", 1'b1);

      // R6: full-scale error saturates; verdict anomalous even at max threshold
      for (int i = 0; i < NF; i++) begin vx[i] = '1; vz[i] = '0; end
      model(es, sat);
      chk(sat && es == 262143, "R6 bench model saturates", es, 262143);
      run_vec((64'sd1 <<< SW) - 1, "R6 saturated vector", 1'b0);

      // R4/R6: pseudo-random sweep with thresholds around the score
      for (int n = 0; n < 300; n++) begin
         longint t;
         int unsigned r;
         for (int i = 0; i < NF; i++) begin
            r = next_rand();
            vx[i] = (n % 3 == 0) ? DW'(r >> 14) : DW'((r >> 14) & 32'h3FFF) + DW'(100000);
            r = next_rand();
            vz[i] = (n % 3 == 0) ? DW'(r >> 14) : DW'((r >> 14) & 32'h3FFF) + DW'(100000);
         end
         model(es, sat);
         r = next_rand();
         t = es + longint'(r % 5) - 2;
         if (t < 0) t = 0;
         if (t > (64'sd1 <<< SW) - 1) t = (64'sd1 <<< SW) - 1;
         run_vec(t, sat ? "R6 sweep saturated" : "R4 sweep", 1'b0);
      end

      // R3/R9: next vector accumulates while the previous one divides
      thr = SW'(100);
      for (int i = 0; i < NF; i++) begin vx[i] = DW'(30000 + i); vz[i] = DW'(10000); end
      model(es, sat);
      for (int i = 0; i < NF; i++) push(vx[i], vz[i]);
      for (int i = 0; i < NF; i++) begin vx[i] = DW'(5000); vz[i] = DW'(5100 + i * 50); end
      model(es2, sat2);
      for (int i = 0; i < NF - 1; i++) push(vx[i], vz[i]);
      wait_strobe(lat);
      check_result(es, sat, "R3 first of overlapped pair");
      push(vx[NF-1], vz[NF-1]);
      wait_strobe(lat);
      check_result(es2, sat2, "R3 second of overlapped pair");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule